// File: doc/BRIEF.md
# Sixteen-Bit Timer-Counter with Buffered Byte Access

The block is a 16-bit up-counter for an 8-bit register bus. It counts either a one-cycle internal tick strobe (the system oscillator divided by four, produced elsewhere) or rising edges on an external clock pin. The selected event goes through a prescaler that divides by 1, 2, 4 or 8. The external pin always passes through a rising-edge detector. A two-flop synchronizer can be placed in front of that detector or bypassed. When the count rolls over from 0xFFFF to 0x0000, an overflow flag is set. A pulse on the trigger input returns the counter to zero.

A control bit selects how software reaches the count. In byte mode the two count bytes are read and written independently. In buffered mode a single high-byte shadow register makes each 16-bit access atomic. Reading the low byte captures the live high byte into the shadow, and a later read of the high byte returns the captured value. A write to the high byte only fills the shadow, and the following low-byte write loads both bytes into the counter in the same cycle.

The edge detector is a two-state machine. In state EXT_LOW the last sample was 0, and a sample of 1 produces a rise pulse and the transition LOW_TO_HIGH. In state EXT_HIGH the last sample was 1, and a sample of 0 produces the transition HIGH_TO_LOW with no pulse. Reset enters EXT_HIGH, so a pin that is already high when reset ends is not counted.

Top module: `tmr16_buffered`

## Requirements
- R1: After reset, the control byte (address 0), both count bytes (address 1 = low, address 2 = high) and the flag byte (address 3) all read 0.
- R2: The control byte has these fields: bit 0 run, bit 1 external source, bit 2 bypass synchronizer, bits 5:4 prescale code, bit 7 buffered mode. Bits 6 and 3 always read 0, so a write of 0xFF reads back as 0xB7.
- R3: With run set and the internal source selected, the count rises by one for every 2^code tick strobes, where code is bits 5:4 (00 = 1, 01 = 2, 10 = 4, 11 = 8). Any write to the count clears the prescaler.
- R4: With run clear, the count does not change, whatever the tick strobe and the external pin do.
- R5: With the external source selected, the count advances only on rising edges of the external pin, and the tick strobe has no effect.
- R6: With the synchronizer in use, the count changes at the third rising system-clock edge after the pin goes high. With it bypassed, the count changes at the first such edge.
- R7: In buffered mode, a read of the low byte copies the live high byte into the shadow. A read of the high byte then returns the shadow, even if the counter has advanced since the low-byte read.
- R8: In buffered mode, a high-byte write changes only the shadow. The next low-byte write loads {shadow, data} into the counter.
- R9: In byte mode, each byte write changes only its own byte of the counter, and a high-byte read returns the live high byte.
- R10: An increment from 0xFFFF wraps the count to 0x0000 and sets the flag (bit 0 of address 3). The flag stays set until a write to address 3 with data bit 0 = 1.
- R11: A trigger pulse clears the counter and the prescaler. It takes priority over a count write and over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Internal count strobe, one cycle wide |
| ext_clk | input | 1 | External count pin |
| evt_trig | input | 1 | Special-event trigger; clears the counter |
| bus_addr | input | 2 | Register select: 0 control, 1 low byte, 2 high byte, 3 flag |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; drives the low-byte read side effect |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, a combinational function of bus_addr |
| ovf_flag | output | 1 | Overflow flag |

## Verification
The inline assertions watch the following on every cycle: the trigger clearing the count, the wrap from 0xFFFF setting the flag, the flag staying set until it is cleared, the count holding while run is clear, the shadow capture on a buffered low-byte read, the count ignoring a buffered high-byte write, and the edge machine's state sequence. Some behaviour can only be shown by the bench's scenarios. These are the exact latency difference between synchronized and bypassed edges, the prescale ratio taken over runs of random ticks, a torn-versus-coherent 16-bit read across a carry, and the register readback masks.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
    typedef enum logic {
        EXT_LOW  = 1'b0,
        EXT_HIGH = 1'b1
    } edge_st_t;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_LO   = 2'd1;
    localparam logic [1:0] ADDR_HI   = 2'd2;
    localparam logic [1:0] ADDR_FLAG = 2'd3;

    localparam int BIT_RUN    = 0;
    localparam int BIT_EXT    = 1;
    localparam int BIT_BYPASS = 2;
    localparam int BIT_PS_LO  = 4;
    localparam int BIT_ATOMIC = 7;

    localparam logic [7:0] CTRL_MASK = 8'hB7;
endpackage

// File: rtl/tmr16_edge.sv
module tmr16_edge
    import tmr16_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_in,
    input  logic bypass,
    output logic rise
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   sample;
    edge_st_t               state_q;
    edge_st_t               state_d;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= ext_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], ext_in};
            end
        end
    endgenerate

    assign sample = bypass ? ext_in : sync_q[SYNC_STAGES-1];

    always_comb begin
        unique case (state_q)
            EXT_LOW:  state_d = sample ? EXT_HIGH : EXT_LOW;
            EXT_HIGH: state_d = sample ? EXT_HIGH : EXT_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EXT_HIGH;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            EXT_LOW:  rise = sample;
            EXT_HIGH: rise = 1'b0;
        endcase
    end

    // R6: a rise pulse always leaves the machine in EXT_HIGH
    a_r6_rise_to_high: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> (state_q == EXT_HIGH));
    // R6: no pulse is ever produced from EXT_HIGH
    a_r6_no_rise_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == EXT_HIGH) |-> !rise);
endmodule

// File: rtl/tmr16_prescale.sv
module tmr16_prescale #(
    parameter int PS_BITS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               evt,
    input  logic [PS_BITS-1:0] sel,
    output logic               inc
);
    localparam int CW = (1 << PS_BITS) - 1;

    logic [CW-1:0] pcnt_q;
    logic [CW-1:0] div_m1;

    always_comb begin
        for (int i = 0; i < CW; i++) begin
            div_m1[i] = (i < int'(sel));
        end
    end

    assign inc = evt && (pcnt_q == div_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pcnt_q <= '0;
        else if (clr)    pcnt_q <= '0;
        else if (inc)    pcnt_q <= '0;
        else if (evt)    pcnt_q <= pcnt_q + 1'b1;
    end

    // R3 / R11: a clear always restarts the division
    a_r3_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (pcnt_q == '0));
    // R3: with no event the prescaler holds
    a_r3_hold_no_evt: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt && !clr) |=> $stable(pcnt_q));
endmodule

// File: rtl/tmr16_buffered.sv
module tmr16_buffered
    import tmr16_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int PS_BITS     = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       ext_clk,
    input  logic       evt_trig,
    input  logic [1:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       ovf_flag
);
    logic [7:0]         ctrl_q;
    logic [15:0]        cnt_q;
    logic [7:0]         shadow_q;
    logic               run, ext_sel, bypass, atomic;
    logic [PS_BITS-1:0] ps_sel;
    logic               rise, src_evt, inc;
    logic               wr_lo, wr_hi, cnt_load, flag_clr, flag_set;

    assign run     = ctrl_q[BIT_RUN];
    assign ext_sel = ctrl_q[BIT_EXT];
    assign bypass  = ctrl_q[BIT_BYPASS];
    assign atomic  = ctrl_q[BIT_ATOMIC];
    assign ps_sel  = ctrl_q[BIT_PS_LO +: PS_BITS];

    tmr16_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .ext_in (ext_clk),
        .bypass (bypass),
        .rise   (rise)
    );

    assign src_evt = run && (ext_sel ? rise : tick_en);

    assign wr_lo    = bus_wr && (bus_addr == ADDR_LO);
    assign wr_hi    = bus_wr && (bus_addr == ADDR_HI) && !atomic;
    assign cnt_load = wr_lo || wr_hi;
    assign flag_clr = bus_wr && (bus_addr == ADDR_FLAG) && bus_wdata[0];
    assign flag_set = inc && (cnt_q == 16'hFFFF) && !evt_trig && !cnt_load;

    tmr16_prescale #(.PS_BITS(PS_BITS)) u_ps (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (evt_trig || cnt_load),
        .evt   (src_evt),
        .sel   (ps_sel),
        .inc   (inc)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (bus_wr && (bus_addr == ADDR_CTRL))
            ctrl_q <= bus_wdata & CTRL_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= '0;
        else if (evt_trig) cnt_q <= '0;
        else if (wr_lo)    cnt_q <= {(atomic ? shadow_q : cnt_q[15:8]), bus_wdata};
        else if (wr_hi)    cnt_q <= {bus_wdata, cnt_q[7:0]};
        else if (inc)      cnt_q <= cnt_q + 16'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            shadow_q <= '0;
        else if (atomic && bus_wr && (bus_addr == ADDR_HI))
            shadow_q <= bus_wdata;
        else if (atomic && bus_rd && (bus_addr == ADDR_LO))
            shadow_q <= cnt_q[15:8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ovf_flag <= 1'b0;
        else        ovf_flag <= flag_set || (ovf_flag && !flag_clr);
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_CTRL: bus_rdata = ctrl_q;
            ADDR_LO:   bus_rdata = cnt_q[7:0];
            ADDR_HI:   bus_rdata = atomic ? shadow_q : cnt_q[15:8];
            ADDR_FLAG: bus_rdata = {7'd0, ovf_flag};
        endcase
    end

    // R11: trigger wins over everything
    a_r11_trig_clears: assert property (@(posedge clk) disable iff (!rst_n)
        evt_trig |=> (cnt_q == 16'd0));
    // R10: wrap from all ones gives zero and a raised flag
    a_r10_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && (cnt_q == 16'hFFFF) && !evt_trig && !cnt_load) |=> (ovf_flag && (cnt_q == 16'd0)));
    // R10: flag is sticky until cleared
    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !flag_clr) |=> ovf_flag);
    // R4: stopped counter holds
    a_r4_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !evt_trig && !cnt_load) |=> $stable(cnt_q));
    // R7: buffered low-byte read captures the live high byte
    a_r7_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
        (atomic && bus_rd && !bus_wr && (bus_addr == ADDR_LO)) |=> (shadow_q == $past(cnt_q[15:8])));
    // R8: buffered high-byte write leaves the counter untouched
    a_r8_hi_write_held: assert property (@(posedge clk) disable iff (!rst_n)
        (atomic && bus_wr && (bus_addr == ADDR_HI) && !evt_trig && !inc) |=> $stable(cnt_q));
endmodule

// File: tb/tmr16_buffered_test.sv
module tmr16_buffered_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       ext_clk = 1'b0;
    logic       evt_trig = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       ovf_flag;

    int checks = 0;
    int fails  = 0;

    tmr16_buffered uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ext_clk(ext_clk),
        .evt_trig(evt_trig), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ovf_flag(ovf_flag)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bwr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic brd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk);
        #1 bus_rd = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        tick_en = 1'b1;
        @(posedge clk);
        #1 tick_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic read16(output logic [15:0] v);
        logic [7:0] lo, hi;
        brd(2'd1, lo);
        brd(2'd2, hi);
        v = {hi, lo};
    endtask

    function automatic logic [15:0] expect_count(input logic [15:0] start, input int n, input int code);
        return start + 16'(n / (1 << code));
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0]  d;
        logic [15:0] v;
        int unsigned seed;
        seed = $urandom(32'h5EED);

        idle(3);
        #1 rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            brd(2'(a), d);
            chk("R1 reset readback", {8'd0, d}, 16'd0);
        end

        // R2 control mask
        bwr(2'd0, 8'hFF);
        brd(2'd0, d);
        chk("R2 ctrl readback", {8'd0, d}, 16'h00B7);

        // R4 stopped: ticks ignored
        bwr(2'd0, 8'h00);
        bwr(2'd1, 8'h34);
        bwr(2'd2, 8'h12);
        for (int i = 0; i < 10; i++) tick();
        read16(v);
        chk("R4 stopped counter", v, 16'h1234);

        // R3 directed: prescale 1:8
        bwr(2'd0, 8'h31);
        for (int i = 0; i < 17; i++) tick();
        read16(v);
        chk("R3 prescale 8", v, 16'h1236);

        // R3 random prescale runs
        for (int it = 0; it < 20; it++) begin
            int code, n;
            logic [15:0] st;
            code = int'($urandom % 4);
            st   = 16'($urandom);
            n    = int'($urandom % 40);
            bwr(2'd0, {2'b00, 2'(code), 4'b0001});
            bwr(2'd1, st[7:0]);
            bwr(2'd2, st[15:8]);
            for (int i = 0; i < n; i++) begin
                tick();
                idle(int'($urandom % 3));
            end
            read16(v);
            chk("R3 random prescale", v, expect_count(st, n, code));
        end

        // R9 byte-mode write touches only its byte
        bwr(2'd0, 8'h00);
        bwr(2'd1, 8'hAA);
        bwr(2'd2, 8'h55);
        bwr(2'd1, 8'h0F);
        read16(v);
        chk("R9 byte write", v, 16'h550F);

        // R8 buffered high write goes to shadow only
        bwr(2'd0, 8'h80);
        bwr(2'd2, 8'h77);
        bwr(2'd0, 8'h00);
        read16(v);
        chk("R8 hi write held", v, 16'h550F);
        bwr(2'd0, 8'h80);
        bwr(2'd2, 8'h12);
        bwr(2'd1, 8'hFF);
        bwr(2'd0, 8'h00);
        read16(v);
        chk("R8 joint load", v, 16'h12FF);

        // R7 coherent read across carry
        bwr(2'd0, 8'h81);
        brd(2'd1, d);
        chk("R7 low byte", {8'd0, d}, 16'h00FF);
        tick();
        brd(2'd2, d);
        chk("R7 shadow high", {8'd0, d}, 16'h0012);
        // R9 live high in byte mode
        bwr(2'd0, 8'h01);
        brd(2'd2, d);
        chk("R9 live high", {8'd0, d}, 16'h0013);

        // R10 overflow
        bwr(2'd1, 8'hFF);
        bwr(2'd2, 8'hFF);
        tick();
        read16(v);
        chk("R10 wrap", v, 16'h0000);
        brd(2'd3, d);
        chk("R10 flag set", {8'd0, d}, 16'h0001);
        bwr(2'd3, 8'h00);
        brd(2'd3, d);
        chk("R10 flag kept", {8'd0, d}, 16'h0001);
        bwr(2'd3, 8'h01);
        brd(2'd3, d);
        chk("R10 flag cleared", {8'd0, d}, 16'h0000);

        // R11 trigger beats increment and write
        bwr(2'd1, 8'h34);
        bwr(2'd2, 8'h12);
        @(negedge clk);
        evt_trig = 1'b1; tick_en = 1'b1;
        @(posedge clk);
        #1 evt_trig = 1'b0; tick_en = 1'b0;
        read16(v);
        chk("R11 trig vs tick", v, 16'h0000);
        bwr(2'd1, 8'h21);
        @(negedge clk);
        evt_trig = 1'b1; bus_addr = 2'd1; bus_wdata = 8'h99; bus_wr = 1'b1;
        @(posedge clk);
        #1 evt_trig = 1'b0; bus_wr = 1'b0;
        read16(v);
        chk("R11 trig vs write", v, 16'h0000);

        // R5 external source ignores ticks
        bwr(2'd0, 8'h03);
        idle(4);
        for (int i = 0; i < 5; i++) tick();
        read16(v);
        chk("R5 ticks ignored", v, 16'h0000);

        // R6 synchronized latency: count changes at third edge
        @(negedge clk);
        ext_clk = 1'b1; bus_addr = 2'd1;
        #1 chk("R6 sync edge0", {8'd0, bus_rdata}, 16'h0000);
        @(negedge clk); chk("R6 sync edge1", {8'd0, bus_rdata}, 16'h0000);
        @(negedge clk); chk("R6 sync edge2", {8'd0, bus_rdata}, 16'h0000);
        @(negedge clk); chk("R6 sync edge3", {8'd0, bus_rdata}, 16'h0001);
        idle(4);
        chk("R5 level held no count", {8'd0, bus_rdata}, 16'h0001);
        @(negedge clk); ext_clk = 1'b0;
        idle(4);

        // R6 bypassed latency: first edge
        bwr(2'd0, 8'h07);
        idle(2);
        @(negedge clk);
        ext_clk = 1'b1; bus_addr = 2'd1;
        #1 chk("R6 bypass edge0", {8'd0, bus_rdata}, 16'h0001);
        @(negedge clk); chk("R6 bypass edge1", {8'd0, bus_rdata}, 16'h0002);
        @(negedge clk); ext_clk = 1'b0;
        idle(2);

        // R4 stopped with external edges
        bwr(2'd0, 8'h06);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); ext_clk = 1'b1;
            @(negedge clk); ext_clk = 1'b0;
        end
        read16(v);
        chk("R4 stopped ext", v, 16'h0002);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule